// File: doc/BRIEF.md
# Parallel Bus Master Interface

This block lets a local processor run single transfers on a shared, asynchronous parallel system bus. A local requester pulses a start strobe with a transfer kind and an access size. The block then requests the bus and wins it through a daisy-chained priority scheme. It raises the bus-busy line and drives one of four active-low command strobes, together with a byte-high enable. It holds the strobe until the addressed slave returns a transfer acknowledge.

If no acknowledge comes back within a fixed window, the block drops the strobe. It reports completion with an error flag, so the processor can resume instead of stalling on a missing device. The window is set from the reference clock rate and the timeout in microseconds. The defaults are 10 MHz and 12 µs, which gives 120 clock cycles.

Once the block has won the bus, it keeps it until the local side stops issuing work. There is no tenure limit. A new start given in the cycle that completion is reported chains straight into the next command without arbitrating again. Bus lock, inhibit, common request and parallel priority are not part of this block. All inputs are sampled on the rising edge of `clk`.

Top module: `parallel_bus_master`

## Requirements
- R1: While `rst_n` is low and after reset, all command strobes, `byte_hi_n`, `busy_out_n` and `bus_req_n` are high, `loc_ack` and `loc_err` are low, and `prio_out_n` equals `prio_in_n`.
- R2: After a `loc_start` pulse from idle, `bus_req_n` is low from the next cycle. The block takes the bus only after an edge at which `prio_in_n` is low and `busy_in_n` is high. It then drives `busy_out_n` low and raises the command strobe in the cycle after that edge. At any other edge it keeps waiting with no strobe active.
- R3: While `bus_req_n` is high, `prio_out_n` follows `prio_in_n`. While `bus_req_n` is low, `prio_out_n` is high.
- R4: `loc_kind` selects the strobe: 0 gives `mem_rd_n`, 1 gives `mem_wr_n`, 2 gives `io_rd_n` and 3 gives `io_wr_n`. No more than one strobe is low at any time.
- R5: During a command, `byte_hi_n` is low when `loc_word` was 1 at start and high when it was 0.
- R6: A low `xfer_ack_n` sampled while a strobe is active ends the command at that edge. In the next cycle the strobes are high and `loc_ack` is high for exactly one cycle with `loc_err` low.
- R7: If no acknowledge arrives, the strobe stays low for exactly CLK_MHZ*TIMEOUT_US cycles (120 by default). It is then released, and `loc_ack` and `loc_err` are both high for one cycle.
- R8: In the cycle with `loc_ack` high, `busy_out_n` and `bus_req_n` stay low. They go high one cycle later, together, unless `loc_start` is high in that cycle. In that case the next command strobe appears one cycle later without re-arbitration and with `busy_out_n` kept low.
- R9: A `loc_start` pulse while a request or command is in progress, apart from the completion cycle, is ignored. The current command keeps its strobe, and no further command follows it.
- R10: After the bus is taken, `busy_out_n` stays low until completion whatever `prio_in_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timeout reference |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_start | input | 1 | One-cycle start pulse from the local side |
| loc_kind | input | 2 | Transfer kind: 0 mem read, 1 mem write, 2 I/O read, 3 I/O write |
| loc_word | input | 1 | 1 = word access, 0 = byte access |
| loc_ack | output | 1 | One-cycle completion pulse |
| loc_err | output | 1 | Completion was a timeout (valid with loc_ack) |
| prio_in_n | input | 1 | Daisy-chain priority in, active low |
| prio_out_n | output | 1 | Daisy-chain priority out, active low |
| bus_req_n | output | 1 | Bus request, active low |
| busy_in_n | input | 1 | Bus busy from other masters, active low |
| busy_out_n | output | 1 | Bus busy driven by this master, active low |
| mem_rd_n | output | 1 | Memory read command strobe |
| mem_wr_n | output | 1 | Memory write command strobe |
| io_rd_n | output | 1 | I/O read command strobe |
| io_wr_n | output | 1 | I/O write command strobe |
| byte_hi_n | output | 1 | Byte-high enable, active low |
| xfer_ack_n | input | 1 | Transfer acknowledge from the slave, active low |

## Verification
With priority present, `bus_req_n` falls one edge after the start pulse and the strobe appears one edge later. An acknowledge sampled at edge N clears the strobe and raises `loc_ack` at N+1, and the bus is released at N+2. The bench drives every input at the falling edge and reads outputs at the next falling edge. That way each check lands halfway through the cycle the count above predicts. The timeout check counts falling edges with the strobe low and expects exactly the computed window. A scoreboard queue holds the expected error flag for every started transfer and matches it against each `loc_ack` pulse in order.

// File: rtl/pbm_pkg.sv
// Shared types for the parallel bus master: transfer kinds and sequencer states.
package pbm_pkg;
    localparam int N_KIND = 4;
    localparam int KIND_W = $clog2(N_KIND);

    // Transfer kind; the value indexes the command strobe vector.
    typedef enum logic [KIND_W-1:0] {
        K_MEM_RD = 2'd0,
        K_MEM_WR = 2'd1,
        K_IO_RD  = 2'd2,
        K_IO_WR  = 2'd3
    } xfer_kind_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_CMD,
        ST_HOLD
    } seq_state_e;
endpackage

// File: rtl/pbm_arbiter.sv
// Daisy-chain priority gate.
// Passes priority downstream while this master is not requesting, blocks it
// while requesting, and flags when the bus may be taken (priority held and
// no other master busy). Assumes inputs are already synchronous to clk.
module pbm_arbiter (
    input  logic want,
    input  logic prio_in_n,
    input  logic busy_in_n,
    output logic prio_out_n,
    output logic bus_req_n,
    output logic may_take
);
    // Request line and priority chain follow the request state directly.
    always_comb begin
        bus_req_n  = !want;
        prio_out_n = prio_in_n | want;
        may_take   = !prio_in_n && busy_in_n;
    end
endmodule

// File: rtl/pbm_timeout.sv
// Acknowledge watchdog.
// Counts clock cycles while a command is active and raises expire in the
// LIMIT-th active cycle. Clears whenever run is low. Assumes LIMIT >= 2.
module pbm_timeout #(
    parameter int LIMIT = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Cycle counter for the active command.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (!expire) cnt <= cnt + 1'b1;
    end

    // Window ends on the last allowed cycle.
    assign expire = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/pbm_strobes.sv
// Command strobe decoder.
// Drives one active-low strobe per transfer kind while active, and the
// byte-high enable for word accesses. Assumes kind is stable while active.
module pbm_strobes
    import pbm_pkg::*;
#(
    parameter int NK = N_KIND
) (
    input  logic              active,
    input  logic [KIND_W-1:0] kind,
    input  logic              word,
    output logic [NK-1:0]     strb_n,
    output logic              byte_hi_n
);
    // One decoder slice per strobe.
    for (genvar i = 0; i < NK; i++) begin : g_strb
        assign strb_n[i] = !(active && (kind == KIND_W'(i)));
    end

    // Upper byte lane enabled only for word accesses.
    assign byte_hi_n = !(active && word);
endmodule

// File: rtl/parallel_bus_master.sv
// Parallel bus master interface (top).
// Sequences one local transfer at a time: request, daisy-chain arbitration,
// command strobe until acknowledge or timeout, one hold cycle, then release
// or chain into a new command. Assumes all bus inputs are synchronous to clk
// and that loc_start is a single-cycle pulse.
module parallel_bus_master
    import pbm_pkg::*;
#(
    parameter int CLK_MHZ    = 10,
    parameter int TIMEOUT_US = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_start,
    input  logic [KIND_W-1:0] loc_kind,
    input  logic              loc_word,
    output logic              loc_ack,
    output logic              loc_err,
    input  logic              prio_in_n,
    output logic              prio_out_n,
    output logic              bus_req_n,
    input  logic              busy_in_n,
    output logic              busy_out_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              byte_hi_n,
    input  logic              xfer_ack_n
);
    localparam int TMO_CYCLES = CLK_MHZ * TIMEOUT_US;

    seq_state_e        state;
    logic [KIND_W-1:0] kind_q;
    logic              word_q;
    logic              err_q;
    logic              want;
    logic              may_take;
    logic              in_cmd;
    logic              expire;
    logic [N_KIND-1:0] strb_n;

    assign want   = (state != ST_IDLE);
    assign in_cmd = (state == ST_CMD);

    pbm_arbiter u_arb (
        .want      (want),
        .prio_in_n (prio_in_n),
        .busy_in_n (busy_in_n),
        .prio_out_n(prio_out_n),
        .bus_req_n (bus_req_n),
        .may_take  (may_take)
    );

    pbm_timeout #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_cmd),
        .expire(expire)
    );

    pbm_strobes u_strb (
        .active   (in_cmd),
        .kind     (kind_q),
        .word     (word_q),
        .strb_n   (strb_n),
        .byte_hi_n(byte_hi_n)
    );

    // Transfer sequencer and captured transfer attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= '0;
            word_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (loc_start) begin
                    kind_q <= loc_kind;
                    word_q <= loc_word;
                    state  <= ST_ARB;
                end
                ST_ARB: if (may_take) state <= ST_CMD;
                ST_CMD: begin
                    if (!xfer_ack_n) begin
                        err_q <= 1'b0;
                        state <= ST_HOLD;
                    end else if (expire) begin
                        err_q <= 1'b1;
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (loc_start) begin
                        kind_q <= loc_kind;
                        word_q <= loc_word;
                        state  <= ST_CMD;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Local completion and bus ownership outputs.
    always_comb begin
        loc_ack    = (state == ST_HOLD);
        loc_err    = (state == ST_HOLD) && err_q;
        busy_out_n = !((state == ST_CMD) || (state == ST_HOLD));
    end

    // Strobe vector order follows the transfer kind encoding.
    assign mem_rd_n = strb_n[K_MEM_RD];
    assign mem_wr_n = strb_n[K_MEM_WR];
    assign io_rd_n  = strb_n[K_IO_RD];
    assign io_wr_n  = strb_n[K_IO_WR];
endmodule

// File: rtl/pbm_checker.sv
// Protocol checker for the parallel bus master, attached by bind.
// Observes ports only; keeps its own strobe-length counter.
module pbm_checker #(
    parameter int CLK_MHZ    = 10,
    parameter int TIMEOUT_US = 12
) (
    input logic clk,
    input logic rst_n,
    input logic loc_ack,
    input logic loc_err,
    input logic prio_in_n,
    input logic prio_out_n,
    input logic bus_req_n,
    input logic busy_in_n,
    input logic busy_out_n,
    input logic mem_rd_n,
    input logic mem_wr_n,
    input logic io_rd_n,
    input logic io_wr_n
);
    localparam int TMO = CLK_MHZ * TIMEOUT_US;
    localparam int CW  = $clog2(TMO + 2);

    logic [3:0]    strb_act;
    logic          any_strb;
    logic [CW-1:0] run_len;

    assign strb_act = ~{io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};
    assign any_strb = |strb_act;

    // Length of the current uninterrupted strobe run.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_len <= '0;
        else if (any_strb) run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb_act));

    assert_strobe_owns_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_strb |-> !busy_out_n);

    assert_take_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_out_n) |-> $past(!prio_in_n && busy_in_n));

    assert_prio_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_n |-> prio_out_n);

    assert_prio_passed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_n |-> (prio_out_n == prio_in_n));

    assert_ack_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |-> (!any_strb && $past(any_strb)));

    assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |=> !loc_ack);

    assert_strobe_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        any_strb |-> (run_len < CW'(TMO)));

    assert_err_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_err |-> loc_ack);

    assert_release_together_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_out_n) |-> (bus_req_n && $past(loc_ack)));
endmodule

bind parallel_bus_master pbm_checker #(
    .CLK_MHZ   (CLK_MHZ),
    .TIMEOUT_US(TIMEOUT_US)
) u_pbm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_ack   (loc_ack),
    .loc_err   (loc_err),
    .prio_in_n (prio_in_n),
    .prio_out_n(prio_out_n),
    .bus_req_n (bus_req_n),
    .busy_in_n (busy_in_n),
    .busy_out_n(busy_out_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n)
);

// File: tb/tb_parallel_bus_master.sv
// Scoreboard bench: tasks push the expected completion flag per transfer,
// a monitor pops and compares on every loc_ack pulse.
module tb_parallel_bus_master;
    localparam int CLK_PERIOD = 100;
    localparam int TMO_EXP    = 10 * 12;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       loc_start, loc_word;
    logic [1:0] loc_kind;
    logic       loc_ack, loc_err;
    logic       prio_in_n, prio_out_n, bus_req_n;
    logic       busy_in_n, busy_out_n;
    logic       mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, byte_hi_n;
    logic       xfer_ack_n;
    logic [3:0] strb;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  exp_q[$];

    assign strb = {io_wr_n, io_rd_n, mem_wr_n, mem_rd_n};

    always #(CLK_PERIOD / 2) clk = ~clk;

    parallel_bus_master dut (
        .clk(clk), .rst_n(rst_n), .loc_start(loc_start), .loc_kind(loc_kind),
        .loc_word(loc_word), .loc_ack(loc_ack), .loc_err(loc_err),
        .prio_in_n(prio_in_n), .prio_out_n(prio_out_n), .bus_req_n(bus_req_n),
        .busy_in_n(busy_in_n), .busy_out_n(busy_out_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .byte_hi_n(byte_hi_n), .xfer_ack_n(xfer_ack_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: every completion pulse is matched against the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && loc_ack === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected completion", 1, 0);
            end else begin
                automatic bit e = exp_q.pop_front();
                check(loc_err == e, "R6/R7 completion error flag", int'(loc_err), int'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end

    task automatic issue(input logic [1:0] k, input logic w, input bit exp_err);
        @(negedge clk);
        loc_start = 1'b1; loc_kind = k; loc_word = w;
        exp_q.push_back(exp_err);
        @(negedge clk);
        loc_start = 1'b0;
        check(bus_req_n == 1'b0, "R2 request raised", int'(bus_req_n), 0);
    endtask

    task automatic check_cmd(input logic [1:0] k, input logic w, input string tag);
        logic [3:0] want;
        want = ~(4'b0001 << k);
        check(strb == want, {tag, " R4 strobe select"}, int'(strb), int'(want));
        check(byte_hi_n == !w, {tag, " R5 byte-high"}, int'(byte_hi_n), int'(!w));
        check(busy_out_n == 1'b0, {tag, " R2 busy driven"}, int'(busy_out_n), 0);
    endtask

    task automatic finish_ack(input int d, input logic [1:0] k);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            check(strb == ~(4'b0001 << k), "R6 strobe held until ack", int'(strb), int'(~(4'b0001 << k)));
        end
        xfer_ack_n = 1'b0;
        @(negedge clk);
        xfer_ack_n = 1'b1;
        check(strb == 4'hF, "R6 strobe released after ack", int'(strb), 15);
        check(busy_out_n == 1'b0, "R8 busy kept in completion cycle", int'(busy_out_n), 0);
    endtask

    task automatic release_check();
        @(negedge clk);
        check(busy_out_n == 1'b1 && bus_req_n == 1'b1, "R8 bus released",
              int'({busy_out_n, bus_req_n}), 3);
    endtask

    initial begin
        rst_n = 1'b0; loc_start = 1'b0; loc_kind = 2'd0; loc_word = 1'b0;
        prio_in_n = 1'b0; busy_in_n = 1'b1; xfer_ack_n = 1'b1;
        repeat (3) @(negedge clk);
        check(strb == 4'hF && byte_hi_n && busy_out_n && bus_req_n, "R1 bus outputs idle in reset",
              int'({strb, byte_hi_n, busy_out_n, bus_req_n}), 127);
        check(!loc_ack && !loc_err, "R1 no completion in reset", int'({loc_ack, loc_err}), 0);
        check(prio_out_n == prio_in_n, "R1 priority passes in reset", int'(prio_out_n), int'(prio_in_n));
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_out_n && bus_req_n && strb == 4'hF, "R1 idle after reset",
              int'({busy_out_n, bus_req_n}), 3);

        // Memory read, word, immediate acknowledge.
        issue(2'd0, 1'b1, 1'b0);
        @(negedge clk);
        check_cmd(2'd0, 1'b1, "mem rd");
        finish_ack(0, 2'd0);
        release_check();

        // Memory write, byte, acknowledge after three cycles.
        issue(2'd1, 1'b0, 1'b0);
        @(negedge clk);
        check_cmd(2'd1, 1'b0, "mem wr");
        finish_ack(3, 2'd1);
        release_check();

        // I/O read and I/O write.
        issue(2'd2, 1'b1, 1'b0);
        @(negedge clk);
        check_cmd(2'd2, 1'b1, "io rd");
        finish_ack(1, 2'd2);
        release_check();
        issue(2'd3, 1'b0, 1'b0);
        @(negedge clk);
        check_cmd(2'd3, 1'b0, "io wr");
        finish_ack(1, 2'd3);
        release_check();

        // Unacknowledged cycle times out.
        issue(2'd2, 1'b0, 1'b1);
        @(negedge clk);
        check_cmd(2'd2, 1'b0, "timeout");
        begin
            int n = 1;
            for (int i = 0; i < 1000; i++) begin
                @(negedge clk);
                if (strb == 4'hF) break;
                n++;
            end
            check(n == TMO_EXP, "R7 strobe length on timeout", n, TMO_EXP);
        end
        release_check();

        // Idle priority pass-through.
        for (int v = 0; v < 2; v++) begin
            prio_in_n = v[0];
            #1;
            check(prio_out_n == v[0], "R3 idle pass-through", int'(prio_out_n), v);
        end

        // Arbitration wait, then hold regardless of priority.
        prio_in_n = 1'b1;
        issue(2'd1, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(busy_out_n == 1'b1 && strb == 4'hF, "R2 wait without priority",
                  int'(busy_out_n), 1);
            check(prio_out_n == 1'b1, "R3 priority blocked while requesting", int'(prio_out_n), 1);
        end
        prio_in_n = 1'b0; busy_in_n = 1'b0;
        @(negedge clk);
        check(busy_out_n == 1'b1 && strb == 4'hF, "R2 wait while bus busy", int'(busy_out_n), 1);
        busy_in_n = 1'b1;
        @(negedge clk);
        check_cmd(2'd1, 1'b1, "granted");
        prio_in_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(busy_out_n == 1'b0 && mem_wr_n == 1'b0, "R10 bus held after priority loss",
                  int'(busy_out_n), 0);
        end
        finish_ack(0, 2'd1);
        prio_in_n = 1'b0;
        release_check();

        // Back-to-back: start in the completion cycle chains without release.
        issue(2'd0, 1'b1, 1'b0);
        @(negedge clk);
        check_cmd(2'd0, 1'b1, "chain first");
        xfer_ack_n = 1'b0;
        @(negedge clk);
        xfer_ack_n = 1'b1;
        check(busy_out_n == 1'b0, "R8 busy kept at chain point", int'(busy_out_n), 0);
        loc_start = 1'b1; loc_kind = 2'd3; loc_word = 1'b0;
        exp_q.push_back(1'b0);
        @(negedge clk);
        loc_start = 1'b0;
        check_cmd(2'd3, 1'b0, "R8 chained command");
        finish_ack(0, 2'd3);
        release_check();

        // Start during a command is ignored.
        issue(2'd0, 1'b0, 1'b0);
        @(negedge clk);
        check_cmd(2'd0, 1'b0, "busy start");
        loc_start = 1'b1; loc_kind = 2'd3; loc_word = 1'b1;
        @(negedge clk);
        loc_start = 1'b0;
        check_cmd(2'd0, 1'b0, "R9 command unchanged");
        finish_ack(0, 2'd0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(busy_out_n == 1'b1 && strb == 4'hF, "R9 no extra command",
                  int'({busy_out_n, strb}), 31);
        end

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R6 every transfer completed", exp_q.size(), 0);
        report();
    end
endmodule